// File: doc/BRIEF.md
# Isolated Bus State Link Transmitter and Watchdog

This block connects two halves of a split two-wire bus. It carries the local clock/data logic state across an isolating link as short pulse-coded messages on a pair of lines that rest low. It also watches the opposite direction for decoded messages and tells the local pin drivers whether, and to which levels, they may drive. A message goes out whenever the local clock or data level changes. When nothing has changed for a keep-alive period, the current state is sent again so that the far side's watchdog stays satisfied.

On the receive side, decoded messages arrive as a one-cycle strobe with a 2-bit code and two payload bits. A state message updates the remote levels. A disconnect notice from the far side (stuck bus or link timeout) makes this side release its pins. If no message of any kind arrives within the timeout window, this side releases its pins and sends one timeout notice. A local stuck-bus event does the same and sends a stuck-bus notice. After a disconnect, driving resumes only when the buses are quiet and a fresh state message has then been received.

The transmit path has two state machines. The scheduler moves through OFF, IDLE and SEND: OFF to IDLE when transmit is enabled, IDLE to SEND when a message is pending and the framer is free, SEND to IDLE when the framer finishes, and any state to OFF when transmit is disabled. The framer moves through IDLE, MARK and SPACE: IDLE to MARK on a start, MARK to SPACE after one pulse width, SPACE to MARK for the next pulse, SPACE to IDLE after the last pulse, and any state to IDLE when disabled. The receive guard moves through OFF, WAIT, LINK and DISC: OFF to WAIT when receive is enabled, WAIT to LINK on a state message, WAIT or LINK to DISC on a timeout, a notice or a local stuck event, DISC to WAIT when the buses are quiet and no timeout is pending, and any state to OFF when receive is disabled.

Top module: `bridge_link_xfer`

## Requirements
- R1: After reset, txp and txn are low, drive_en and link_timeout are low, and rem_scl and rem_sda are high.
- R2: Framing. Every message opens with one pulse on txp. It then carries 2 code bits, MSB first, and for code 00 the payload bits scl and then sda. A bit of 1 is a txp pulse followed by a txn pulse, and a bit of 0 is a txn pulse followed by a txp pulse. Every pulse is high for PULSE_W cycles and is followed by PULSE_W cycles with both lines low. txp and txn are never high together.
- R3: A change of loc_scl or loc_sda causes a state message (code 00) carrying the current levels.
- R4: With no change, a state message is repeated between KEEPALIVE_CYC and KEEPALIVE_CYC+3 cycles after the start of the previous state message.
- R5: A change that happens while a message is being sent is held. A state message with the latest levels starts within 4 cycles after the current message ends.
- R6: When several messages are pending, a stuck-bus notice (code 01) goes first, then a timeout notice (code 10), then a state message.
- R7: While tx_en is low, both lines stay low and nothing is sent, even if the inputs change. When tx_en rises, a state message is sent.
- R8: A received state message (rx_valid with code 00) while rx_en is high copies rx_scl/rx_sda to rem_scl/rem_sda, and from WAIT it asserts drive_en.
- R9: If no message is received for RX_TIMEOUT_CYC cycles, link_timeout rises and drive_en falls. Exactly one timeout notice (code 10) is sent. link_timeout clears when the next message arrives.
- R10: A received notice (code 01 or 10) deasserts drive_en on the following cycle.
- R11: A stuck_evt pulse deasserts drive_en and causes one stuck-bus notice (code 01) to be sent.
- R12: After a disconnect, received state messages do not re-enable driving until bus_quiet has been seen with no timeout pending. After that, the next state message asserts drive_en.
- R13: While rx_en is low, the watchdog is held cleared: link_timeout and drive_en stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| loc_scl | input | 1 | Externally driven local clock level |
| loc_sda | input | 1 | Externally driven local data level |
| stuck_evt | input | 1 | One-cycle local stuck-bus event |
| bus_quiet | input | 1 | Both buses idle or stopped |
| rx_valid | input | 1 | Decoded message strobe |
| rx_code | input | 2 | Decoded message code |
| rx_scl | input | 1 | Decoded remote clock level |
| rx_sda | input | 1 | Decoded remote data level |
| txp | output | 1 | Positive pulse line |
| txn | output | 1 | Negative pulse line |
| rem_scl | output | 1 | Remote clock level to drive |
| rem_sda | output | 1 | Remote data level to drive |
| drive_en | output | 1 | Local pins may be driven |
| link_timeout | output | 1 | Receive watchdog expired |

## Verification
A wrong scheduler state shows at the line pair within one message time. It appears as a missing or duplicated message, a wrong payload, or a keep-alive arriving off its window. The bench decodes every pulse into messages and checks code, payload and start cycle. A framer that loses its place breaks the pulse-pair rule or the pulse width, and the bench counts that on the very pulse where it happens. A wrong guard state shows on drive_en or link_timeout one cycle after the offending receive strobe, or at the watchdog limit. The watchdog is checked both shortly before and shortly after that limit.

// File: rtl/blx_pkg.sv
package blx_pkg;
    typedef enum logic [1:0] {
        MSG_STATE = 2'b00,
        MSG_STUCK = 2'b01,
        MSG_TMO   = 2'b10
    } msg_code_e;
endpackage

// File: rtl/blx_framer.sv
module blx_framer
    import blx_pkg::*;
#(
    parameter int PULSE_W = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  logic      start,
    input  msg_code_e code,
    input  logic      pay_scl,
    input  logic      pay_sda,
    output logic      busy,
    output logic      txp,
    output logic      txn
);
    localparam int TW = $clog2(PULSE_W + 1);
    localparam logic [TW-1:0] T_LAST = TW'(PULSE_W - 1);

    typedef enum logic [1:0] {F_IDLE, F_MARK, F_SPACE} fstate_e;

    fstate_e        st_q;
    logic [TW-1:0]  tcnt_q;
    logic [3:0]     pidx_q;
    logic [3:0]     last_q;
    logic [3:0]     bits_q;
    logic           cur_p;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= F_IDLE;
            tcnt_q <= '0;
            pidx_q <= '0;
            last_q <= '0;
            bits_q <= '0;
        end else if (!en) begin
            st_q   <= F_IDLE;
            tcnt_q <= '0;
            pidx_q <= '0;
        end else begin
            unique case (st_q)
                F_IDLE: begin
                    if (start) begin
                        st_q   <= F_MARK;
                        tcnt_q <= '0;
                        pidx_q <= '0;
                        bits_q <= {code, pay_scl, pay_sda};
                        last_q <= (code == MSG_STATE) ? 4'd8 : 4'd4;
                    end
                end
                F_MARK: begin
                    if (tcnt_q == T_LAST) begin
                        st_q   <= F_SPACE;
                        tcnt_q <= '0;
                    end else begin
                        tcnt_q <= tcnt_q + 1'b1;
                    end
                end
                F_SPACE: begin
                    if (tcnt_q == T_LAST) begin
                        tcnt_q <= '0;
                        if (pidx_q == last_q) begin
                            st_q <= F_IDLE;
                        end else begin
                            st_q   <= F_MARK;
                            pidx_q <= pidx_q + 4'd1;
                            if (pidx_q != 4'd0 && !pidx_q[0])
                                bits_q <= {bits_q[2:0], 1'b0};
                        end
                    end else begin
                        tcnt_q <= tcnt_q + 1'b1;
                    end
                end
                default: st_q <= F_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        if (pidx_q == 4'd0) cur_p = 1'b1;
        else if (pidx_q[0]) cur_p = bits_q[3];
        else                cur_p = ~bits_q[3];
        busy = (st_q != F_IDLE);
        txp  = (st_q == F_MARK) && cur_p;
        txn  = (st_q == F_MARK) && !cur_p;
    end

    a_r2_not_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(txp && txn));
    a_r2_space_after: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(txp) |-> !txn);
    a_r7_en_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!busy && !txp && !txn));
endmodule

// File: rtl/blx_sched.sv
module blx_sched
    import blx_pkg::*;
#(
    parameter int KEEPALIVE_CYC = 115000
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tx_en,
    input  logic      loc_scl,
    input  logic      loc_sda,
    input  logic      stuck_evt,
    input  logic      tmo_evt,
    input  logic      busy,
    output logic      start,
    output msg_code_e code,
    output logic      pay_scl,
    output logic      pay_sda
);
    localparam int KW = $clog2(KEEPALIVE_CYC + 1);
    localparam logic [KW-1:0] KA_LAST = KW'(KEEPALIVE_CYC - 1);

    typedef enum logic [1:0] {S_OFF, S_IDLE, S_SEND} sstate_e;

    sstate_e       st_q;
    logic          prev_scl_q, prev_sda_q;
    logic          pend_state_q, pend_stk_q, pend_tmo_q;
    logic [KW-1:0] ka_q;
    logic          chg, ka_hit, iss_state, iss_stk, iss_tmo;

    assign chg       = (loc_scl != prev_scl_q) || (loc_sda != prev_sda_q);
    assign ka_hit    = (ka_q == KA_LAST);
    assign iss_state = start && (code == MSG_STATE);
    assign iss_stk   = start && (code == MSG_STUCK);
    assign iss_tmo   = start && (code == MSG_TMO);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= S_OFF;
            prev_scl_q   <= 1'b1;
            prev_sda_q   <= 1'b1;
            pend_state_q <= 1'b0;
            pend_stk_q   <= 1'b0;
            pend_tmo_q   <= 1'b0;
            ka_q         <= '0;
        end else if (!tx_en) begin
            st_q         <= S_OFF;
            prev_scl_q   <= loc_scl;
            prev_sda_q   <= loc_sda;
            pend_state_q <= 1'b0;
            pend_stk_q   <= 1'b0;
            pend_tmo_q   <= 1'b0;
            ka_q         <= '0;
        end else begin
            prev_scl_q   <= loc_scl;
            prev_sda_q   <= loc_sda;
            pend_state_q <= (pend_state_q | chg | ka_hit) & ~iss_state;
            pend_stk_q   <= stuck_evt | (pend_stk_q & ~iss_stk);
            pend_tmo_q   <= tmo_evt | (pend_tmo_q & ~iss_tmo);
            if (iss_state)   ka_q <= '0;
            else if (!ka_hit) ka_q <= ka_q + 1'b1;
            unique case (st_q)
                S_OFF: begin
                    st_q         <= S_IDLE;
                    pend_state_q <= 1'b1;
                end
                S_IDLE: if (start) st_q <= S_SEND;
                S_SEND: if (!busy) st_q <= S_IDLE;
                default: st_q <= S_OFF;
            endcase
        end
    end

    // outputs
    always_comb begin
        start   = (st_q == S_IDLE) && !busy
                  && (pend_stk_q || pend_tmo_q || pend_state_q);
        if (pend_stk_q)      code = MSG_STUCK;
        else if (pend_tmo_q) code = MSG_TMO;
        else                 code = MSG_STATE;
        pay_scl = loc_scl;
        pay_sda = loc_sda;
    end

    a_r5_start_framer_free: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_SEND) |-> !start);
endmodule

// File: rtl/blx_guard.sv
module blx_guard
    import blx_pkg::*;
#(
    parameter int RX_TIMEOUT_CYC = 460000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_en,
    input  logic       rx_valid,
    input  logic [1:0] rx_code,
    input  logic       rx_scl,
    input  logic       rx_sda,
    input  logic       stuck_evt,
    input  logic       bus_quiet,
    output logic       rem_scl,
    output logic       rem_sda,
    output logic       drive_en,
    output logic       link_timeout,
    output logic       tmo_evt
);
    localparam int WW = $clog2(RX_TIMEOUT_CYC + 1);
    localparam logic [WW-1:0] WD_LAST = WW'(RX_TIMEOUT_CYC - 1);

    typedef enum logic [1:0] {G_OFF, G_WAIT, G_LINK, G_DISC} gstate_e;

    gstate_e       st_q;
    logic [WW-1:0] wd_q;
    logic          lt_q, evt_q, rs_q, rd_q;
    logic          fire, is_state, is_notice, drop;

    assign fire      = rx_en && !rx_valid && !lt_q && (wd_q == WD_LAST);
    assign is_state  = rx_valid && (rx_code == MSG_STATE);
    assign is_notice = rx_valid && ((rx_code == MSG_STUCK) || (rx_code == MSG_TMO));
    assign drop      = fire || stuck_evt || is_notice;

    // watchdog and remote levels
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wd_q  <= '0;
            lt_q  <= 1'b0;
            evt_q <= 1'b0;
            rs_q  <= 1'b1;
            rd_q  <= 1'b1;
        end else begin
            evt_q <= 1'b0;
            if (!rx_en) begin
                wd_q <= '0;
                lt_q <= 1'b0;
            end else if (rx_valid) begin
                wd_q <= '0;
                lt_q <= 1'b0;
                if (is_state) begin
                    rs_q <= rx_scl;
                    rd_q <= rx_sda;
                end
            end else if (fire) begin
                lt_q  <= 1'b1;
                evt_q <= 1'b1;
            end else if (!lt_q) begin
                wd_q <= wd_q + 1'b1;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= G_OFF;
        end else if (!rx_en) begin
            st_q <= G_OFF;
        end else begin
            unique case (st_q)
                G_OFF:  st_q <= G_WAIT;
                G_WAIT: if (drop) st_q <= G_DISC;
                        else if (is_state) st_q <= G_LINK;
                G_LINK: if (drop) st_q <= G_DISC;
                G_DISC: if (bus_quiet && !lt_q && !drop) st_q <= G_WAIT;
                default: st_q <= G_OFF;
            endcase
        end
    end

    // outputs
    always_comb begin
        drive_en     = (st_q == G_LINK);
        link_timeout = lt_q;
        tmo_evt      = evt_q;
        rem_scl      = rs_q;
        rem_sda      = rd_q;
    end

    a_r9_timeout_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        link_timeout |-> !drive_en);
    a_r10_notice_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && is_notice) |=> !drive_en);
    a_r13_off_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (!link_timeout && !drive_en));
    a_r8_rem_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && is_state) |=> (rem_scl == $past(rx_scl) && rem_sda == $past(rx_sda)));
endmodule

// File: rtl/bridge_link_xfer.sv
module bridge_link_xfer
    import blx_pkg::*;
#(
    parameter int PULSE_W        = 4,
    parameter int KEEPALIVE_CYC  = 115000,
    parameter int RX_TIMEOUT_CYC = 460000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_en,
    input  logic       rx_en,
    input  logic       loc_scl,
    input  logic       loc_sda,
    input  logic       stuck_evt,
    input  logic       bus_quiet,
    input  logic       rx_valid,
    input  logic [1:0] rx_code,
    input  logic       rx_scl,
    input  logic       rx_sda,
    output logic       txp,
    output logic       txn,
    output logic       rem_scl,
    output logic       rem_sda,
    output logic       drive_en,
    output logic       link_timeout
);
    logic      busy, start, pay_scl, pay_sda, tmo_evt;
    msg_code_e code;

    blx_sched #(.KEEPALIVE_CYC(KEEPALIVE_CYC)) u_sched (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en),
        .loc_scl(loc_scl), .loc_sda(loc_sda),
        .stuck_evt(stuck_evt), .tmo_evt(tmo_evt), .busy(busy),
        .start(start), .code(code), .pay_scl(pay_scl), .pay_sda(pay_sda)
    );

    blx_framer #(.PULSE_W(PULSE_W)) u_framer (
        .clk(clk), .rst_n(rst_n), .en(tx_en), .start(start), .code(code),
        .pay_scl(pay_scl), .pay_sda(pay_sda),
        .busy(busy), .txp(txp), .txn(txn)
    );

    blx_guard #(.RX_TIMEOUT_CYC(RX_TIMEOUT_CYC)) u_guard (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_valid(rx_valid),
        .rx_code(rx_code), .rx_scl(rx_scl), .rx_sda(rx_sda),
        .stuck_evt(stuck_evt), .bus_quiet(bus_quiet),
        .rem_scl(rem_scl), .rem_sda(rem_sda), .drive_en(drive_en),
        .link_timeout(link_timeout), .tmo_evt(tmo_evt)
    );
endmodule

// File: tb/sim_bridge_link_xfer.sv
module sim_bridge_link_xfer;
    localparam int PW  = 2;
    localparam int KA  = 200;
    localparam int TMO = 400;
    localparam int MSG_LEN = 9 * 2 * PW;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0, tx_en = 1'b0, rx_en = 1'b0;
    logic loc_scl = 1'b1, loc_sda = 1'b1, stuck_evt = 1'b0, bus_quiet = 1'b0;
    logic rx_valid = 1'b0, rx_scl = 1'b1, rx_sda = 1'b1;
    logic [1:0] rx_code = 2'b00;
    logic txp, txn, rem_scl, rem_sda, drive_en, link_timeout;

    bridge_link_xfer #(.PULSE_W(PW), .KEEPALIVE_CYC(KA), .RX_TIMEOUT_CYC(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
        .loc_scl(loc_scl), .loc_sda(loc_sda), .stuck_evt(stuck_evt),
        .bus_quiet(bus_quiet), .rx_valid(rx_valid), .rx_code(rx_code),
        .rx_scl(rx_scl), .rx_sda(rx_sda), .txp(txp), .txn(txn),
        .rem_scl(rem_scl), .rem_sda(rem_sda), .drive_en(drive_en),
        .link_timeout(link_timeout)
    );

    int checks = 0, errors = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // line decoder
    int mcount = 0;
    int m_code[256], m_scl[256], m_sda[256], m_t[256];
    int dn = 0, t_start = 0, dec_bad = 0, wbad = 0, prun = 0, nrun = 0;
    logic [8:1] sb;
    logic txp_q = 1'b0, txn_q = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (txp && txn) wbad++;
            if (txp) prun++; else begin if (txp_q && prun != PW) wbad++; prun = 0; end
            if (txn) nrun++; else begin if (txn_q && nrun != PW) wbad++; nrun = 0; end
            if ((txp && !txp_q) || (txn && !txn_q)) begin
                if (dn == 0) begin
                    if (txp) begin dn = 1; t_start = cyc; end
                    else dec_bad++;
                end else begin
                    sb[dn] = txp;
                    dn++;
                    if (dn == 5 || dn == 9) begin
                        if (sb[1] == sb[2] || sb[3] == sb[4]) dec_bad++;
                        if (dn == 9 && (sb[5] == sb[6] || sb[7] == sb[8])) dec_bad++;
                        if (dn == 9 || {sb[1], sb[3]} != 2'b00) begin
                            if (mcount < 256) begin
                                m_code[mcount] = int'({sb[1], sb[3]});
                                m_scl[mcount]  = (dn == 9) ? int'(sb[5]) : 0;
                                m_sda[mcount]  = (dn == 9) ? int'(sb[7]) : 0;
                                m_t[mcount]    = t_start;
                            end
                            mcount++;
                            dn = 0;
                        end
                    end
                end
            end
            txp_q = txp;
            txn_q = txn;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_rx(input logic [1:0] c, input logic s, input logic d);
        @(negedge clk);
        rx_valid = 1'b1; rx_code = c; rx_scl = s; rx_sda = d;
        @(negedge clk);
        rx_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 txp", int'(txp), 0);
        chk("R1 txn", int'(txn), 0);
        chk("R1 drive_en", int'(drive_en), 0);
        chk("R1 link_timeout", int'(link_timeout), 0);
        chk("R1 rem_scl", int'(rem_scl), 1);
        chk("R1 rem_sda", int'(rem_sda), 1);
    endtask

    task automatic t_enable();
        int base = mcount;
        tx_en = 1'b1;
        wait_cyc(MSG_LEN + 20);
        chk("R7 enable sends one", mcount - base, 1);
        chk("R2 code state", m_code[base], 0);
        chk("R2 scl payload", m_scl[base], 1);
        chk("R2 sda payload", m_sda[base], 1);
    endtask

    task automatic t_change();
        int base = mcount;
        loc_sda = 1'b0;
        wait_cyc(MSG_LEN + 14);
        chk("R3 change sends one", mcount - base, 1);
        chk("R3 scl", m_scl[base], 1);
        chk("R3 sda", m_sda[base], 0);
    endtask

    task automatic t_latch();
        int base = mcount;
        loc_sda = 1'b1;
        wait_cyc(5);
        loc_scl = 1'b0;
        wait_cyc(2 * MSG_LEN + 28);
        chk("R5 two messages", mcount - base, 2);
        chk("R5 first sda", m_sda[base], 1);
        chk("R5 first scl", m_scl[base], 1);
        chk("R5 second scl latest", m_scl[base + 1], 0);
        chk("R5 second sda latest", m_sda[base + 1], 1);
        chk_rng("R5 back to back", m_t[base + 1] - m_t[base], MSG_LEN, MSG_LEN + 4);
    endtask

    task automatic t_keepalive();
        int base = mcount;
        wait_cyc(250);
        chk("R4 one resend", mcount - base, 1);
        chk_rng("R4 resend gap", m_t[base] - m_t[base - 1], KA, KA + 3);
        chk("R4 same scl", m_scl[base], 0);
        chk("R4 same sda", m_sda[base], 1);
    endtask

    task automatic t_disable();
        int base;
        tx_en = 1'b0;
        wait_cyc(2);
        base = mcount;
        loc_sda = 1'b0; wait_cyc(10);
        loc_scl = 1'b1; wait_cyc(10);
        loc_sda = 1'b1;
        wait_cyc(KA + 100);
        chk("R7 silent while off", mcount - base, 0);
        chk("R7 txp low", int'(txp), 0);
        chk("R13 no timeout rx off", int'(link_timeout), 0);
        chk("R13 no drive rx off", int'(drive_en), 0);
        base = mcount;
        tx_en = 1'b1;
        wait_cyc(MSG_LEN + 20);
        chk("R7 reenable sends", mcount - base, 1);
        chk("R7 reenable payload sda", m_sda[base], 1);
    endtask

    task automatic t_priority();
        int base = mcount;
        @(negedge clk);
        stuck_evt = 1'b1;
        loc_sda = 1'b0;
        @(negedge clk);
        stuck_evt = 1'b0;
        wait_cyc(2 * MSG_LEN + 20);
        chk("R6 stuck notice first", m_code[base], 1);
        chk("R11 stuck notice sent", m_code[base], 1);
        chk("R6 state second", m_code[base + 1], 0);
        chk("R6 state payload", m_sda[base + 1], 0);
    endtask

    task automatic t_rx_link();
        rx_en = 1'b1;
        wait_cyc(2);
        send_rx(2'b00, 1'b0, 1'b1);
        chk("R8 drive after state", int'(drive_en), 1);
        chk("R8 rem_scl", int'(rem_scl), 0);
        chk("R8 rem_sda", int'(rem_sda), 1);
        send_rx(2'b00, 1'b1, 1'b0);
        chk("R8 rem_scl update", int'(rem_scl), 1);
        chk("R8 rem_sda update", int'(rem_sda), 0);
    endtask

    task automatic t_rx_notice();
        send_rx(2'b01, 1'b0, 1'b0);
        chk("R10 stuck notice drops", int'(drive_en), 0);
        send_rx(2'b00, 1'b1, 1'b1);
        chk("R12 no drive before quiet", int'(drive_en), 0);
        @(negedge clk); bus_quiet = 1'b1;
        @(negedge clk); bus_quiet = 1'b0;
        chk("R12 quiet alone no drive", int'(drive_en), 0);
        send_rx(2'b00, 1'b1, 1'b1);
        chk("R12 drive after quiet+state", int'(drive_en), 1);
        send_rx(2'b10, 1'b0, 1'b0);
        chk("R10 timeout notice drops", int'(drive_en), 0);
        @(negedge clk); bus_quiet = 1'b1;
        @(negedge clk); bus_quiet = 1'b0;
        send_rx(2'b00, 1'b1, 1'b1);
        chk("R12 relinked", int'(drive_en), 1);
    endtask

    task automatic t_watchdog();
        int base = mcount;
        int n10 = 0;
        wait_cyc(TMO - 20);
        chk("R9 not early", int'(link_timeout), 0);
        chk("R9 still driving", int'(drive_en), 1);
        wait_cyc(30);
        chk("R9 timeout set", int'(link_timeout), 1);
        chk("R9 drive dropped", int'(drive_en), 0);
        wait_cyc(TMO + 100);
        for (int i = base; i < mcount && i < 256; i++)
            if (m_code[i] == 2) n10++;
        chk("R9 one timeout notice", n10, 1);
        send_rx(2'b00, 1'b1, 1'b1);
        chk("R9 timeout cleared", int'(link_timeout), 0);
    endtask

    task automatic t_rx_off();
        wait_cyc(TMO + 20);
        chk("R9 timed out again", int'(link_timeout), 1);
        rx_en = 1'b0;
        wait_cyc(2);
        chk("R13 cleared by rx off", int'(link_timeout), 0);
        chk("R13 drive low", int'(drive_en), 0);
    endtask

    bit done = 1'b0;

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(2);
        t_reset();
        t_enable();
        t_change();
        t_latch();
        t_keepalive();
        t_disable();
        t_priority();
        t_rx_link();
        t_rx_notice();
        t_watchdog();
        t_rx_off();
        chk("R2 pulse width and overlap", wbad, 0);
        chk("R2 pulse pairing", dec_bad, 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule